// File: doc/BRIEF.md
# Multiplexed Bus Target Controller

This block is the slave side of a 32-bit parallel bus whose address and data share one set of lines and whose control lines are active low. When an initiator starts a transaction, the block captures the address and the 4-bit command from the first cycle in which the frame line is low. It then checks them against one memory window and one small configuration window. If they match, it claims the transaction by pulling its device-select line low after a decode delay set at build time. Data phases move words between the bus and a small internal register file. A word moves only on a clock edge where both ready lines are low. During data phases the byte enables are active low and mask the bytes of a write.

The block can end a transaction in several ways. Normal completion happens when the initiator marks the last phase. A disconnect happens at the window end or in single-beat mode. A retry happens when the busy input is set, and a target abort happens when the error input is set. The pads are not modelled as tri-state: the address/data output and the three target control lines each come with an output-enable. An external pad ring combines them with the bus.

Top module: `mux_bus_target`

## Requirements
- R1: During reset and until the first claim, trdyN, devselN and stopN are 1 and adOe and ctlOe are 0.
- R2: Take the address phase as cycle 1. A claimed transaction sees devselN low first in cycle 2+DEVSEL_DLY (DEVSEL_DLY 0, 1 or 2), and trdyN is never low while devselN is high.
- R3: Only command codes 0110, 1100 and 1110 (reads) and 0111 and 1111 (writes) claim the memory window, which is MEM_WORDS words starting at MEM_BASE. All other codes are never claimed in the memory window, including 0000 to 0101, 1000, 1001 and 1101.
- R4: Codes 1010 (read) and 1011 (write) claim the configuration window only when idSel is 1 in the address cycle and the address has bits [1:0]=00, bits [10:8]=000 and bits [7:2] below CFG_WORDS. Bits [31:11] are ignored. Configuration register r is file word MEM_WORDS+r.
- R5: On a read, trdyN stays 1 and adOe stays 0 in cycle 2, the turnaround cycle.
- R6: A data phase completes only on an edge where irdyN and trdyN are both 0. Once trdyN is 0 it, and devselN, stay 0 until that phase completes.
- R7: On a write phase, byte b (bits 8b+7:8b) of the addressed word is written only when cbeN[b] is 0. A phase with cbeN=1111 changes nothing but still moves the burst to the next word.
- R8: When a phase completes with frameN at 1, the next cycle has trdyN, devselN and stopN at 1 with ctlOe still 1, and the cycle after that has ctlOe at 0.
- R9: After a completed phase on the last word of its window, with frameN still 0, the block raises trdyN and lowers stopN (disconnect without data).
- R10: With singleBeat set in the address cycle, the first data phase drives trdyN and stopN low together, so exactly one word moves.
- R11: With busyIn set in the address cycle, the block claims and drives stopN low without ever lowering trdyN (retry). No data moves.
- R12: With errIn set in the address cycle, devselN is low for one cycle and then goes high while stopN goes low (target abort). No data moves.
- R13: Once stopN is low it stays low until frameN is sampled at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Transaction in progress, active low |
| irdyN | input | 1 | Initiator ready, active low |
| idSel | input | 1 | Configuration select for this device |
| adIn | input | 32 | Address/data lines as seen by the block |
| cbeN | input | 4 | Command in the address cycle, active-low byte enables afterwards |
| busyIn | input | 1 | Forces a retry of the transaction being claimed |
| errIn | input | 1 | Forces a target abort of the transaction being claimed |
| singleBeat | input | 1 | Forces a disconnect with data on the first transfer |
| adOut | output | 32 | Read data for the address/data lines |
| adOe | output | 1 | Drive enable for adOut |
| trdyN | output | 1 | Target ready, active low |
| devselN | output | 1 | Device select, active low |
| stopN | output | 1 | Stop request, active low |
| ctlOe | output | 1 | Drive enable for trdyN, devselN and stopN |

## Verification
Some rules are checked by assertions on every clock edge. Reserved and unsupported codes never lead to a claim. The turnaround cycle of a read stays quiet. Target ready and device select hold while the initiator waits. Stop holds until the frame rises. A write with every byte disabled leaves its word alone. Configuration claims require the select line. Other behaviour can only be seen in the bench's transaction scenarios: the exact claim cycle, the byte merge for every one of the sixteen enable patterns, read data in burst order, the cycle in which a disconnect lands at the window end, and how retry, abort and single-beat termination are told apart from the outside.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLAIM,
    ST_RESP,
    ST_DATA,
    ST_HOLD,
    ST_REL
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchAddr;
    logic writeBeat;
    logic advance;
  } dpStrobe_t;

  function automatic logic isMemCmd(input logic [3:0] code);
    return (code == 4'b0110) || (code == 4'b0111) || (code == 4'b1100) ||
           (code == 4'b1110) || (code == 4'b1111);
  endfunction

  function automatic logic isCfgCmd(input logic [3:0] code);
    return code[3:1] == 3'b101;
  endfunction

endpackage

// File: rtl/mbt_dpath.sv
module mbt_dpath
  import mbt_pkg::*;
#(
  parameter logic [31:0] MEM_BASE  = 32'h8000_0000,
  parameter int          MEM_WORDS = 4,
  parameter int          CFG_WORDS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  input  logic        idSel,
  input  dpStrobe_t   strobe,
  output logic        hit,
  output logic        lastWord,
  output logic [31:0] rdData
);

  localparam int NWORDS  = MEM_WORDS + CFG_WORDS;
  localparam int IDXW    = $clog2(NWORDS);
  localparam int MEM_LSB = $clog2(MEM_WORDS) + 2;

  logic [31:0]     rf [NWORDS];
  logic [IDXW-1:0] idx;
  logic [IDXW-1:0] startIdx;
  logic            inCfg;
  logic            memHit;
  logic            cfgHit;
  logic [31:0]     curWord;

  always_comb begin
    memHit = isMemCmd(cbeN) && (adIn[31:MEM_LSB] == MEM_BASE[31:MEM_LSB]);
    cfgHit = isCfgCmd(cbeN) && idSel && (adIn[1:0] == 2'b00) &&
             (adIn[10:8] == 3'b000) && ({26'd0, adIn[7:2]} < CFG_WORDS);
    hit    = memHit || cfgHit;
    if (cfgHit) startIdx = IDXW'(MEM_WORDS) + IDXW'(adIn[7:2]);
    else        startIdx = IDXW'(adIn[MEM_LSB-1:2]);
  end

  assign lastWord = inCfg ? (idx == IDXW'(NWORDS - 1)) : (idx == IDXW'(MEM_WORDS - 1));
  assign curWord  = rf[idx];
  assign rdData   = curWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx   <= '0;
      inCfg <= 1'b0;
    end else if (strobe.latchAddr) begin
      idx   <= startIdx;
      inCfg <= cfgHit;
    end else if (strobe.advance) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NWORDS; w++) rf[w] <= '0;
    end else if (strobe.writeBeat) begin
      for (int b = 0; b < 4; b++) begin
        if (!cbeN[b]) rf[idx][8*b +: 8] <= adIn[8*b +: 8];
      end
    end
  end

  // R7: a fully masked write beat leaves its word untouched
  p_masked_beat_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeBeat && (&cbeN) |=> rf[$past(idx)] == $past(curWord));

  // R4: a configuration claim needs the select line
  p_cfg_select_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchAddr && hit && isCfgCmd(cbeN) |-> idSel);

endmodule

// File: rtl/mbt_ctrl.sv
module mbt_ctrl
  import mbt_pkg::*;
#(
  parameter int DEVSEL_DLY = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic [3:0] cbeN,
  input  logic       busyIn,
  input  logic       errIn,
  input  logic       singleBeat,
  input  logic       hit,
  input  logic       lastWord,
  output dpStrobe_t  strobe,
  output logic       trdyN,
  output logic       devselN,
  output logic       stopN,
  output logic       adOe,
  output logic       ctlOe
);

  tgtState_e  state;
  logic       prevFrameN;
  logic [1:0] cnt;
  logic       wrL, busyL, errL, oneL;
  logic       start, xfer, wrE, busyE, errE, oneE;
  logic       claimNow, respNow, abortNow;

  always_comb begin
    start    = (state == ST_IDLE) && !frameN && prevFrameN;
    xfer     = (state == ST_DATA) && !irdyN && !trdyN;
    wrE      = (state == ST_IDLE) ? cbeN[0]    : wrL;
    busyE    = (state == ST_IDLE) ? busyIn     : busyL;
    errE     = (state == ST_IDLE) ? errIn      : errL;
    oneE     = (state == ST_IDLE) ? singleBeat : oneL;
    claimNow = (start && hit && (DEVSEL_DLY == 0)) || ((state == ST_CLAIM) && (cnt == 2'd1));
    // a read claimed on the address edge must let the turnaround cycle pass
    respNow  = (claimNow && !errE && !((state == ST_IDLE) && !wrE)) ||
               ((state == ST_RESP) && !errL);
    abortNow = (state == ST_RESP) && errL;
    strobe.latchAddr = start;
    strobe.writeBeat = xfer && wrL;
    strobe.advance   = xfer;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      prevFrameN <= 1'b1;
      cnt        <= '0;
      wrL        <= 1'b0;
      busyL      <= 1'b0;
      errL       <= 1'b0;
      oneL       <= 1'b0;
      trdyN      <= 1'b1;
      devselN    <= 1'b1;
      stopN      <= 1'b1;
      adOe       <= 1'b0;
      ctlOe      <= 1'b0;
    end else begin
      prevFrameN <= frameN;
      if (claimNow) devselN <= 1'b0;
      if (respNow) begin
        if (busyE) begin
          stopN <= 1'b0;
          state <= ST_HOLD;
        end else begin
          trdyN <= 1'b0;
          stopN <= !oneE;
          adOe  <= !wrE;
          state <= ST_DATA;
        end
      end else if (claimNow) begin
        state <= ST_RESP;
      end
      case (state)
        ST_IDLE: begin
          if (start && hit) begin
            ctlOe <= 1'b1;
            wrL   <= cbeN[0];
            busyL <= busyIn;
            errL  <= errIn;
            oneL  <= singleBeat;
            if (DEVSEL_DLY != 0) begin
              cnt   <= 2'(DEVSEL_DLY);
              state <= ST_CLAIM;
            end
          end
        end
        ST_CLAIM: if (cnt != 2'd1) cnt <= cnt - 2'd1;
        ST_RESP: begin
          if (abortNow) begin
            devselN <= 1'b1;
            stopN   <= 1'b0;
            state   <= ST_HOLD;
          end
        end
        ST_DATA: begin
          if (xfer) begin
            if (frameN) begin
              trdyN   <= 1'b1;
              devselN <= 1'b1;
              stopN   <= 1'b1;
              adOe    <= 1'b0;
              state   <= ST_REL;
            end else if (!stopN || lastWord) begin
              trdyN <= 1'b1;
              stopN <= 1'b0;
              adOe  <= 1'b0;
              state <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (frameN) begin
            trdyN   <= 1'b1;
            devselN <= 1'b1;
            stopN   <= 1'b1;
            adOe    <= 1'b0;
            state   <= ST_REL;
          end
        end
        ST_REL: begin
          ctlOe <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_reserved_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    start && ((cbeN == 4'b0100) || (cbeN == 4'b0101) || (cbeN == 4'b1000) ||
              (cbeN == 4'b1001) || (cbeN == 4'b1101)) |=> devselN && !ctlOe);

  p_read_turnaround_r5: assert property (@(posedge clk) disable iff (!rstN)
    start && !cbeN[0] |=> trdyN && !adOe);

  p_trdy_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN && irdyN |=> !trdyN);

  p_devsel_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !devselN && !trdyN && irdyN |=> !devselN);

  p_trdy_needs_devsel_r2: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !devselN);

  p_stop_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !stopN && !frameN |=> !stopN);

endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target
  import mbt_pkg::*;
#(
  parameter logic [31:0] MEM_BASE   = 32'h8000_0000,
  parameter int          MEM_WORDS  = 4,
  parameter int          CFG_WORDS  = 4,
  parameter int          DEVSEL_DLY = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        idSel,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  input  logic        busyIn,
  input  logic        errIn,
  input  logic        singleBeat,
  output logic [31:0] adOut,
  output logic        adOe,
  output logic        trdyN,
  output logic        devselN,
  output logic        stopN,
  output logic        ctlOe
);

  dpStrobe_t   strobe;
  logic        hit;
  logic        lastWord;
  logic [31:0] rdData;

  mbt_ctrl #(.DEVSEL_DLY(DEVSEL_DLY)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbeN(cbeN),
    .busyIn(busyIn), .errIn(errIn), .singleBeat(singleBeat),
    .hit(hit), .lastWord(lastWord), .strobe(strobe),
    .trdyN(trdyN), .devselN(devselN), .stopN(stopN), .adOe(adOe), .ctlOe(ctlOe)
  );

  mbt_dpath #(.MEM_BASE(MEM_BASE), .MEM_WORDS(MEM_WORDS), .CFG_WORDS(CFG_WORDS)) u_dpath (
    .clk(clk), .rstN(rstN), .adIn(adIn), .cbeN(cbeN), .idSel(idSel),
    .strobe(strobe), .hit(hit), .lastWord(lastWord), .rdData(rdData)
  );

  assign adOut = adOe ? rdData : '0;

endmodule

// File: tb/test_mux_bus_target.sv
`timescale 1ns/1ps
module test_mux_bus_target;

  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam int MW = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameN, irdyN, idSel, busyIn, errIn, singleBeat;
  logic [31:0] adIn;
  logic [3:0]  cbeN;
  logic [31:0] adOut;
  logic        adOe, trdyN, devselN, stopN, ctlOe;

  int nCmp = 0;
  int nBad = 0;

  logic [31:0] wrData [8];
  logic [3:0]  wrBe   [8];
  logic [31:0] rdData [8];
  logic [31:0] model  [8];
  int   claimCyc, doneCnt, trdyFirst, stopCycles, rdOeBad;
  logic stopped, aborted, oeAt2, relOe1, relOe2, relIdle;

  always #4 clk = ~clk;

  mux_bus_target i_mux_bus_target (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .idSel(idSel),
    .adIn(adIn), .cbeN(cbeN), .busyIn(busyIn), .errIn(errIn), .singleBeat(singleBeat),
    .adOut(adOut), .adOe(adOe), .trdyN(trdyN), .devselN(devselN), .stopN(stopN), .ctlOe(ctlOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one initiator transaction; results land in the globals above
  task automatic busTxn(input logic [3:0] cmd, input logic [31:0] addr, input logic sel, input int nBeats);
    bit fin = 0;
    bit normalEnd = 0;
    int cyc = 1;
    claimCyc = 0; doneCnt = 0; trdyFirst = 0; stopCycles = 0; rdOeBad = 0;
    stopped = 0; aborted = 0; oeAt2 = 0;
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd; idSel = sel;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      if ((claimCyc == 0 && cyc > 6) || cyc > 40) begin
        fin = 1;
      end else begin
        frameN = (stopped || doneCnt >= nBeats - 1) ? 1'b1 : 1'b0;
        irdyN  = 1'b0;
        idSel  = 1'b0;
        adIn   = cmd[0] ? wrData[doneCnt] : 32'h0;
        cbeN   = wrBe[doneCnt];
        if (cyc == 2) oeAt2 = adOe;
        if (!devselN && claimCyc == 0) claimCyc = cyc;
        if (!stopN) begin
          stopped = 1'b1;
          stopCycles++;
          if (devselN && claimCyc != 0) aborted = 1'b1;
        end
        if (!trdyN) begin
          if (trdyFirst == 0) trdyFirst = cyc;
          if (!cmd[0]) begin
            rdData[doneCnt] = adOut;
            if (!adOe) rdOeBad++;
          end
          doneCnt++;
        end
        if (frameN && (!trdyN || !stopN)) begin
          fin = 1;
          normalEnd = 1;
        end
      end
    end
    if (normalEnd) @(negedge clk);
    frameN = 1'b1; irdyN = 1'b1; adIn = '0; cbeN = '0;
    relOe1  = ctlOe;
    relIdle = devselN && trdyN && stopN;
    @(negedge clk);
    relOe2 = ctlOe;
  endtask

  task automatic applyModel(input int baseIdx);
    for (int i = 0; i < doneCnt; i++)
      for (int b = 0; b < 4; b++)
        if (!wrBe[i][b]) model[baseIdx + i][8*b +: 8] = wrData[i][8*b +: 8];
  endtask

  task automatic setBeats(input logic [31:0] seed, input logic [3:0] be);
    for (int i = 0; i < 8; i++) begin
      wrData[i] = seed + 32'h0101_0101 * i;
      wrBe[i]   = be;
    end
  endtask

  initial begin
    #1600000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; frameN = 1'b1; irdyN = 1'b1; idSel = 1'b0; adIn = '0; cbeN = '0;
    busyIn = 1'b0; errIn = 1'b0; singleBeat = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 idle ctl in reset", {29'd0, trdyN, devselN, stopN}, 32'h7);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle ctl after reset", {29'd0, trdyN, devselN, stopN}, 32'h7);
    chk("R1 enables after reset", {30'd0, adOe, ctlOe}, 32'h0);

    // burst write of the whole memory window
    setBeats(32'h1020_3040, 4'h0);
    busTxn(4'b0111, BASE, 1'b0, 4);
    applyModel(0);
    chk("R2 write claim cycle", claimCyc, 2);
    chk("R6 write first trdy cycle", trdyFirst, 2);
    chk("R8 burst beats", doneCnt, 4);
    chk("R8 no stop on normal end", {31'd0, stopped}, 0);
    chk("R8 release drives high", {30'd0, relOe1, relIdle}, 32'h3);
    chk("R8 enable off after release", {31'd0, relOe2}, 0);

    // burst read back
    busTxn(4'b0110, BASE, 1'b0, 4);
    chk("R5 read adOe in cycle 2", {31'd0, oeAt2}, 0);
    chk("R5 read first trdy cycle", trdyFirst, 3);
    chk("R6 read beats", doneCnt, 4);
    chk("R6 adOe during read data", rdOeBad, 0);
    for (int i = 0; i < 4; i++) chk("R6 burst read data", rdData[i], model[i]);

    // every byte-enable pattern on word 1
    for (int be = 0; be < 16; be++) begin
      setBeats(32'h0102_0304 * (be + 3), 4'(be));
      busTxn(4'b0111, BASE + 32'd4, 1'b0, 1);
      applyModel(1);
      busTxn(4'b0110, BASE + 32'd4, 1'b0, 1);
      chk("R7 byte merge", rdData[0], model[1]);
    end

    // masked beat still advances the burst
    setBeats(32'hAB00_0000, 4'h0);
    wrBe[0] = 4'hF;
    busTxn(4'b0111, BASE + 32'd8, 1'b0, 2);
    applyModel(2);
    busTxn(4'b0110, BASE + 32'd8, 1'b0, 2);
    chk("R7 masked word unchanged", rdData[0], model[2]);
    chk("R7 next word written", rdData[1], model[3]);

    // burst running off the window end
    setBeats(32'h5500_0011, 4'h0);
    busTxn(4'b0111, BASE + 32'd8, 1'b0, 3);
    applyModel(2);
    chk("R9 beats before disconnect", doneCnt, 2);
    chk("R9 stop seen", {30'd0, stopped, aborted}, 32'h2);

    // command sweep on the memory window
    setBeats(32'h0, 4'hF);
    for (int c = 0; c < 16; c++) begin
      logic expClaim;
      expClaim = (c == 6) || (c == 7) || (c == 12) || (c == 14) || (c == 15);
      busTxn(4'(c), BASE, 1'b0, 1);
      chk("R3 command claim", {31'd0, claimCyc != 0}, {31'd0, expClaim});
    end

    // configuration window
    setBeats(32'hCAFE_0002, 4'h0);
    busTxn(4'b1011, 32'hFFFF_F008, 1'b1, 1);
    applyModel(MW + 2);
    chk("R4 cfg write claimed", {31'd0, claimCyc != 0}, 1);
    busTxn(4'b1010, 32'h0000_0008, 1'b1, 1);
    chk("R4 cfg read data", rdData[0], model[MW + 2]);
    busTxn(4'b1010, 32'h0000_0008, 1'b0, 1);
    chk("R4 no select no claim", claimCyc, 0);
    busTxn(4'b1010, 32'h0000_0108, 1'b1, 1);
    chk("R4 function nonzero ignored", claimCyc, 0);
    busTxn(4'b1010, 32'h0000_0010, 1'b1, 1);
    chk("R4 register beyond window ignored", claimCyc, 0);
    busTxn(4'b1010, 32'h0000_0009, 1'b1, 1);
    chk("R4 low bits nonzero ignored", claimCyc, 0);

    // single-beat mode
    singleBeat = 1'b1;
    busTxn(4'b0110, BASE, 1'b0, 3);
    singleBeat = 1'b0;
    chk("R10 one word moved", doneCnt, 1);
    chk("R10 stop with data", {30'd0, stopped, aborted}, 32'h2);
    chk("R10 data", rdData[0], model[0]);

    // retry
    busyIn = 1'b1;
    setBeats(32'hDEAD_0000, 4'h0);
    busTxn(4'b0111, BASE, 1'b0, 4);
    busyIn = 1'b0;
    chk("R11 retry claimed", claimCyc, 2);
    chk("R11 no data", doneCnt, 0);
    chk("R11 stop not abort", {30'd0, stopped, aborted}, 32'h2);
    chk("R13 stop held until frame high", stopCycles, 2);
    busTxn(4'b0110, BASE, 1'b0, 1);
    chk("R11 memory unchanged", rdData[0], model[0]);

    // target abort
    errIn = 1'b1;
    busTxn(4'b0111, BASE, 1'b0, 3);
    errIn = 1'b0;
    chk("R12 abort claim cycle", claimCyc, 2);
    chk("R12 abort seen", {30'd0, stopped, aborted}, 32'h3);
    chk("R12 no data", doneCnt, 0);
    busTxn(4'b0110, BASE, 1'b0, 1);
    chk("R12 memory unchanged", rdData[0], model[0]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule